// File: doc/BRIEF.md
# Shared Dual-Port Mailbox Memory with Doorbell

This block is a 2048-byte store that sits between a control processor (the master side) and a single worker processor. Each side has its own byte-wide port and can read or write any location at any time. The two ports run at the same moment without stalls. The 11-bit address picks one of eight 256-byte banks with its top three bits, and the remaining eight bits select the byte inside that bank. Each bank is a separate two-port array, and a registered bank select steers the returned byte to each side.

If both sides write the same byte on the same clock edge, the master's byte is stored and the worker's byte is discarded, so the stored value is always one side's complete byte and never a mix. A one-cycle flag reports each such event. A master write to one reserved address rings a doorbell. That raises an interrupt towards the worker, passed through a two-flop synchroniser, and the interrupt stays raised until the worker acknowledges it. The acknowledge is also passed through a two-flop synchroniser on its way back.

Both ports accept a request on every cycle and there is no back-pressure. A request is a single cycle with `*_en` high. There is no ready signal because the store never refuses an access. Read data appears one cycle later and holds until that port performs its next read.

Top module: `mailbox_dpram`

## Requirements
- R1: Address bits [10:8] select one of eight banks and bits [7:0] the byte within it. A byte written through either port at any of the 2048 addresses is returned by a later read of that address on either port.
- R2: A read (`*_en`=1, `*_we`=0) sampled at clock edge k puts the addressed byte on that port's read data output right after edge k.
- R3: A port's read data output holds its value on every cycle in which that port issues no read, including cycles in which it writes.
- R4: A read on one port that is sampled on the same edge as a write to the same address on the other port returns the byte stored before that write.
- R5: The two ports perform accesses to different addresses in the same cycle independently, and both operations take effect.
- R6: When both ports write the same address on the same edge, the master byte is stored and the worker byte is dropped.
- R7: `wr_collide` is 1 for exactly the one cycle after an edge that sampled a same-address write collision, and is 0 at all other times, including same-address write/read pairs.
- R8: A master write to the doorbell address (default 0x7FF) also stores its byte. It raises `w_irq`, which becomes 1 on the second clock edge after the edge that sampled the write.
- R9: `w_irq` stays at 1 until a rising edge of `w_irq_ack` is sampled. It then falls on the fourth clock edge after that sample. Worker writes to the doorbell address never raise `w_irq`.
- R10: While `rst_n` is low and right after it is released, `w_irq` and `wr_collide` are 0. Reset does not initialise the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of doorbell and collision state |
| m_en | input | 1 | Master access request this cycle |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 11 | Master byte address; bits [10:8] are the bank |
| m_wdata | input | 8 | Master write byte |
| m_rdata | output | 8 | Master read byte, one cycle after the request |
| w_en | input | 1 | Worker access request this cycle |
| w_we | input | 1 | Worker write (1) or read (0) |
| w_addr | input | 11 | Worker byte address; bits [10:8] are the bank |
| w_wdata | input | 8 | Worker write byte |
| w_rdata | output | 8 | Worker read byte, one cycle after the request |
| w_irq | output | 1 | Doorbell interrupt to the worker |
| w_irq_ack | input | 1 | Worker acknowledge; its rising edge clears the doorbell |
| wr_collide | output | 1 | One-cycle pulse after a same-address dual write |

## Verification
A wrong bank decode or offset shows up as a mismatch on the first read that crosses the affected bank. The bench walks every address on both ports, so such a fault is seen within one sweep of 2048 cycles. A wrong collision winner corrupts the target byte, which the next read of it reveals one cycle later. A flag that is late or stretched differs from the pulse in the cycle just after the collision. A doorbell synchroniser with the wrong depth moves the edge of `w_irq` by one cycle against the fixed count of two edges to rise and four edges to fall. A clear path that acts on the level of the acknowledge instead of its edge would still pass, but one that ignores it leaves `w_irq` stuck high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Default geometry of the mailbox store.
  localparam int unsigned MBX_ADDR_W  = 11;
  localparam int unsigned MBX_DATA_W  = 8;
  localparam int unsigned MBX_BANK_W  = 3;
  localparam int unsigned MBX_DB_ADDR = 2047;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W  = 8
) (
  input  logic              clk,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic [OFF_W-1:0]  a_off,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_rd,
  input  logic              b_wr,
  input  logic [OFF_W-1:0]  b_off,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads see the array before this edge's writes (read-old).
  // Port b is written before port a, so a wins if the arbiter ever lets both through.
  always_ff @(posedge clk) begin
    if (a_rd) a_rdata <= mem[a_off];
    if (b_rd) b_rdata <= mem[b_off];
    if (b_wr) mem[b_off] <= b_wdata;
    if (a_wr) mem[a_off] <= a_wdata;
  end
endmodule

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_en,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              w_en,
  input  logic              w_we,
  input  logic [ADDR_W-1:0] w_addr,
  output logic              m_wr,
  output logic              w_wr,
  output logic              collide_q
);
  logic clash;

  always_comb begin
    m_wr  = m_en & m_we;
    clash = m_wr & w_en & w_we & (m_addr == w_addr);
    w_wr  = w_en & w_we & ~clash;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= clash;
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring,
  input  logic ack_in,
  output logic irq_out
);
  logic                   pend;
  logic [SYNC_STAGES-1:0] irq_sync;
  logic [SYNC_STAGES:0]   ack_sync;
  logic                   ack_rise;

  assign ack_rise = ack_sync[SYNC_STAGES-1] & ~ack_sync[SYNC_STAGES];
  assign irq_out  = irq_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      irq_sync <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-1:0], ack_in};
      irq_sync <= {irq_sync[SYNC_STAGES-2:0], pend};
      if (ring)          pend <= 1'b1;
      else if (ack_rise) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/mailbox_dpram.sv
module mailbox_dpram
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W  = MBX_ADDR_W,
  parameter int unsigned DATA_W  = MBX_DATA_W,
  parameter int unsigned BANK_W  = MBX_BANK_W,
  parameter int unsigned DB_ADDR = MBX_DB_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_en,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              w_en,
  input  logic              w_we,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_wdata,
  output logic [DATA_W-1:0] w_rdata,
  output logic              w_irq,
  input  logic              w_irq_ack,
  output logic              wr_collide
);
  localparam int unsigned OFF_W = ADDR_W - BANK_W;
  localparam int unsigned NBANK = 1 << BANK_W;
  localparam logic [ADDR_W-1:0] DB_A = ADDR_W'(DB_ADDR);

  logic              m_wr, w_wr, m_rd, w_rd;
  logic [BANK_W-1:0] m_bank, w_bank, m_sel_q, w_sel_q;
  logic [DATA_W-1:0] bank_m_rdata [NBANK];
  logic [DATA_W-1:0] bank_w_rdata [NBANK];

  assign m_rd   = m_en & ~m_we;
  assign w_rd   = w_en & ~w_we;
  assign m_bank = m_addr[ADDR_W-1:OFF_W];
  assign w_bank = w_addr[ADDR_W-1:OFF_W];

  mbx_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr),
    .w_en(w_en), .w_we(w_we), .w_addr(w_addr),
    .m_wr(m_wr), .w_wr(w_wr), .collide_q(wr_collide)
  );

  mbx_doorbell #(.SYNC_STAGES(2)) u_bell (
    .clk(clk), .rst_n(rst_n),
    .ring(m_wr & (m_addr == DB_A)),
    .ack_in(w_irq_ack),
    .irq_out(w_irq)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_m, hit_w;
    assign hit_m = (m_bank == BANK_W'(b));
    assign hit_w = (w_bank == BANK_W'(b));

    mbx_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_bank (
      .clk(clk),
      .a_rd(m_rd & hit_m), .a_wr(m_wr & hit_m),
      .a_off(m_addr[OFF_W-1:0]), .a_wdata(m_wdata),
      .a_rdata(bank_m_rdata[b]),
      .b_rd(w_rd & hit_w), .b_wr(w_wr & hit_w),
      .b_off(w_addr[OFF_W-1:0]), .b_wdata(w_wdata),
      .b_rdata(bank_w_rdata[b])
    );
  end

  // Bank select follows the last read only, so output holds between reads.
  always_ff @(posedge clk) begin
    if (m_rd) m_sel_q <= m_bank;
    if (w_rd) w_sel_q <= w_bank;
  end

  assign m_rdata = bank_m_rdata[m_sel_q];
  assign w_rdata = bank_w_rdata[w_sel_q];
endmodule

// File: rtl/mailbox_dpram_chk.sv
module mailbox_dpram_chk #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DB_ADDR = 2047
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_en,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_rdata,
  input logic              w_en,
  input logic              w_we,
  input logic [ADDR_W-1:0] w_addr,
  input logic [DATA_W-1:0] w_rdata,
  input logic              w_irq,
  input logic              w_irq_ack,
  input logic              wr_collide
);
  logic dual_wr;
  logic bell_wr;
  assign dual_wr = m_en && m_we && w_en && w_we && (m_addr == w_addr);
  assign bell_wr = m_en && m_we && (m_addr == ADDR_W'(DB_ADDR));

  // R7
  collide_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |-> $past(dual_wr));

  // R7
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_wr |=> wr_collide);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_irq) |-> $past(bell_wr, 3));

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(w_irq) |-> $past(w_irq_ack, 5));

  // R3
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_en && !m_we) |=> $stable(m_rdata));

  // R3
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_en && !w_we) |=> $stable(w_rdata));
endmodule

bind mailbox_dpram mailbox_dpram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DB_ADDR(DB_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_rdata(m_rdata),
  .w_en(w_en), .w_we(w_we), .w_addr(w_addr), .w_rdata(w_rdata),
  .w_irq(w_irq), .w_irq_ack(w_irq_ack), .wr_collide(wr_collide)
);

// File: tb/mailbox_dpram_test.sv
module mailbox_dpram_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_en, m_we, w_en, w_we, w_irq_ack;
  logic [10:0] m_addr, w_addr;
  logic [7:0]  m_wdata, w_wdata;
  logic [7:0]  m_rdata, w_rdata;
  logic        w_irq, wr_collide;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mailbox_dpram uut (
    .clk(clk), .rst_n(rst_n),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .w_en(w_en), .w_we(w_we), .w_addr(w_addr), .w_wdata(w_wdata), .w_rdata(w_rdata),
    .w_irq(w_irq), .w_irq_ack(w_irq_ack), .wr_collide(wr_collide)
  );

  function automatic int pm(int a);
    return (a * 37 + (a >> 8) * 11 + 3) & 255;
  endfunction

  function automatic int pw(int a);
    return (a ^ (a >> 3) ^ 165) & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    m_en = 0; m_we = 0; w_en = 0; w_we = 0; w_irq_ack = 0;
  endtask

  task automatic mreq(bit we, int a, int d);
    m_en = 1; m_we = we; m_addr = 11'(a); m_wdata = 8'(d);
  endtask

  task automatic wreq(bit we, int a, int d);
    w_en = 1; w_we = we; w_addr = 11'(a); w_wdata = 8'(d);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) tick();
    chk("R10 irq in reset", int'(w_irq), 0);
    chk("R10 collide in reset", int'(wr_collide), 0);
    rst_n = 1;
    tick();
    chk("R10 irq after reset", int'(w_irq), 0);
    chk("R10 collide after reset", int'(wr_collide), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_addr = 0; w_addr = 0; m_wdata = 0; w_wdata = 0;
    do_reset();

    // R1 R2 R5: master writes every address while worker reads the previous one
    for (int a = 0; a <= 2048; a++) begin
      idle();
      if (a < 2048) mreq(1, a, pm(a));
      if (a > 0) wreq(0, a - 1, 0);
      tick();
      if (a > 0) chk("R1 R2 R5 worker read", int'(w_rdata), pm(a - 1));
    end

    // R1 R2 R5: worker writes every address while master reads the previous one
    for (int a = 0; a <= 2048; a++) begin
      idle();
      if (a < 2048) wreq(1, a, pw(a));
      if (a > 0) mreq(0, a - 1, 0);
      tick();
      if (a > 0) chk("R1 R2 R5 master read", int'(m_rdata), pw(a - 1));
      chk("R7 no collide on distinct", int'(wr_collide), 0);
    end

    // Master sweep rang the doorbell; start clean.
    do_reset();

    // R3: read value holds over idle cycles and over a write on the same port
    idle(); mreq(0, 300, 0); tick(); idle();
    chk("R2 read 300", int'(m_rdata), pw(300));
    tick(); tick();
    chk("R3 hold idle", int'(m_rdata), pw(300));
    mreq(1, 301, 8'h99); tick(); idle(); tick();
    chk("R3 hold over write", int'(m_rdata), pw(300));

    // R4: master write vs worker read same address
    mreq(1, 12'h200, 8'h11); tick(); idle();
    mreq(1, 12'h200, 8'h22); wreq(0, 12'h200, 0); tick(); idle();
    chk("R4 worker sees old", int'(w_rdata), 8'h11);
    chk("R7 no flag on write/read", int'(wr_collide), 0);
    wreq(0, 12'h200, 0); tick(); idle();
    chk("R4 worker sees new", int'(w_rdata), 8'h22);
    // R4: worker write vs master read same address
    wreq(1, 12'h201, 8'h44); mreq(0, 12'h201, 0); tick(); idle();
    chk("R4 master sees old", int'(m_rdata), pw(12'h201));
    mreq(0, 12'h201, 0); tick(); idle();
    chk("R4 master sees new", int'(m_rdata), 8'h44);

    // R6 R7: same-address write collision in several banks
    for (int k = 0; k < 8; k++) begin
      int a = k * 256 + 35 * k + 7;
      mreq(1, a, 8'hC3 ^ k); wreq(1, a, 8'h3C ^ k); tick(); idle();
      chk("R7 collide pulse", int'(wr_collide), 1);
      tick();
      chk("R7 collide one cycle", int'(wr_collide), 0);
      mreq(0, a, 0); wreq(0, a, 0); tick(); idle();
      chk("R6 master wins (m)", int'(m_rdata), 8'hC3 ^ k);
      chk("R6 master wins (w)", int'(w_rdata), 8'hC3 ^ k);
    end

    // R8: doorbell
    mreq(1, 12'h7FF, 8'h5A); tick(); idle();
    chk("R8 irq not yet 1", int'(w_irq), 0);
    tick();
    chk("R8 irq not yet 2", int'(w_irq), 0);
    tick();
    chk("R8 irq raised", int'(w_irq), 1);
    wreq(0, 12'h7FF, 0); tick(); idle();
    chk("R8 bell byte stored", int'(w_rdata), 8'h5A);
    repeat (10) tick();
    chk("R9 irq held", int'(w_irq), 1);

    // R9: acknowledge
    w_irq_ack = 1; tick(); w_irq_ack = 0;
    chk("R9 irq after ack edge", int'(w_irq), 1);
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R9 irq still high", int'(w_irq), 1);
    end
    tick();
    chk("R9 irq cleared", int'(w_irq), 0);

    // R9: worker write to the doorbell address does not ring
    wreq(1, 12'h7FF, 8'h77); tick(); idle();
    repeat (5) tick();
    chk("R9 worker write no irq", int'(w_irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule